// File: doc/BRIEF.md
# Segmented Write-Back Data Cache

This block sits between a 32-bit load/store pipeline and a word-wide memory port. The upper three address bits choose a window: `100` selects the cached window, `101` selects the uncached window, and every other value is sent straight to memory as if it were uncached. All three windows drop those three bits to form the physical address, so a cached alias and an uncached alias reach the same memory word.

Cached accesses use a 32 KB array with 256 sets and 4 ways of 32-byte lines. The array is write-back and write-allocate, and each set replaces by true least-recently-used order. Uncached accesses make exactly one single-word memory transfer and never read or change the array. Because of this, a dirty line can hide data that was later written through the uncached alias. The hidden data becomes visible only after enough cached traffic has evicted that line. The CPU side takes one request at a time through a valid/ready handshake and answers with a one-cycle response pulse.

The controller is a single state machine with these states:
- `ST_IDLE`: ready for a request. An accepted request goes to `ST_BYPASS` if it is uncached, otherwise to `ST_LOOKUP`.
- `ST_LOOKUP`: compares tags. A hit goes to `ST_COMPLETE`, a miss with a dirty victim goes to `ST_EVICT`, and a miss with a clean or invalid victim goes to `ST_REFILL`.
- `ST_EVICT`: writes back the victim line. After the last word it goes to `ST_REFILL`.
- `ST_REFILL`: fetches the requested line. After the last word it installs the line and goes to `ST_COMPLETE`.
- `ST_COMPLETE`: performs the load or store, updates the LRU order and returns to `ST_IDLE`.
- `ST_BYPASS`: makes one uncached transfer and returns to `ST_IDLE` when memory accepts it.

Top module: `seg_dcache`

## Requirements
- R1: Addresses with bits [31:29] = 100 are cached. Addresses with bits [31:29] = 101, and all addresses outside both windows, are uncached. The physical address is the address AND 0x1FFFFFFF. Every memory transfer carries a physical byte address with bits [31:29] = 000.
- R2: An uncached access makes exactly one memory transfer with mem_burst = 0 at the word-aligned physical address. It leaves tags, valid bits, dirty bits and line data unchanged. A cached read of a resident line therefore still returns the cached word after an uncached write to the same physical address.
- R3: A cached access that hits makes no memory transfer, and a load that hits returns the word held in the line.
- R4: A line fill makes 8 read transfers with mem_burst = 1, in ascending word order starting at the line base. Each transfer holds its address until mem_ready is high.
- R5: A cached store that misses first fills the line and then writes the word, leaving the line dirty. A cached store that hits makes no memory transfer.
- R6: A miss whose victim line is dirty first writes back all 8 victim words in ascending order (mem_write = 1, mem_burst = 1, carrying the cached data). It then performs the 8-word fill.
- R7: The victim is the least recently used way of the set. Hits and fills both make a way the most recent. After reset way 0 is oldest, so invalid ways are always used before valid ones.
- R8: Cached loads over 128 KB of contiguous addresses evict every line that was resident before them, and every dirty line among them is written back.
- R9: After reset, cpu_ready = 1, mem_valid = 0 and cpu_rvalid = 0. cpu_ready is high only when no request is in progress, and mem_valid is never high while cpu_ready is. Each accepted request produces exactly one cpu_rvalid pulse, one cycle long.
- R10: Evicting a clean victim line makes no write transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Request present |
| cpu_ready | output | 1 | Request accepted this cycle when cpu_valid is high |
| cpu_write | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address; bits [1:0] are ignored |
| cpu_wdata | input | 32 | Store data |
| cpu_rvalid | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Load data (echoes the store data for stores) |
| mem_valid | output | 1 | Memory transfer request |
| mem_ready | input | 1 | Memory accepts the transfer; read data is valid in the same cycle |
| mem_write | output | 1 | 1 = write transfer |
| mem_burst | output | 1 | 1 = word of a line fill or writeback, 0 = uncached single transfer |
| mem_addr | output | 32 | Physical byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data |

## Verification
The hardest state to reach from the ports is a dirty line that holds older data than memory holds for the same physical address. Reaching it needs a cached store, then an uncached write to the alias, then a cached read that must still return the stale value. Making that line visible again needs a 128 KB cached sweep. The uncached overwrite has to come after the sweep, because the writeback during the sweep replaces the overwrite with the stale data. A behavioural model of the cache, with one recency queue per set, predicts every memory transfer in order and predicts each load result. Several lines are forced into the same set at an 8 KB stride so that hit-refreshed ordering, silent clean eviction and the order of a dirty writeback are each exercised on purpose.

// File: rtl/dc_pkg.sv
package dc_pkg;
    localparam int XLEN   = 32;
    localparam int PHYS_W = 29;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_EVICT,
        ST_REFILL,
        ST_COMPLETE,
        ST_BYPASS
    } dc_state_e;

    typedef enum logic [1:0] {
        WIN_CACHED,
        WIN_UNCACHED,
        WIN_OTHER
    } dc_window_e;

    function automatic dc_window_e classify(input logic [2:0] top_bits);
        unique case (top_bits)
            3'b100:  return WIN_CACHED;
            3'b101:  return WIN_UNCACHED;
            default: return WIN_OTHER;
        endcase
    endfunction
endpackage

// File: rtl/dc_window_decode.sv
module dc_window_decode
    import dc_pkg::*;
#(
    parameter  int IDX_W  = 8,
    parameter  int OFF_W  = 5,
    localparam int TAG_W  = PHYS_W - IDX_W - OFF_W,
    localparam int WOFF_W = OFF_W - 2
) (
    input  logic [XLEN-1:0]   addr,
    output logic              uncached,
    output logic [XLEN-1:0]   phys_word,
    output logic [IDX_W-1:0]  index,
    output logic [TAG_W-1:0]  tag,
    output logic [WOFF_W-1:0] word
);
    dc_window_e win;
    logic       unused_lsb;

    always_comb begin
        win       = classify(addr[XLEN-1:PHYS_W]);
        uncached  = (win != WIN_CACHED);
        // Drop the window bits and align to a word.
        phys_word = {{(XLEN-PHYS_W){1'b0}}, addr[PHYS_W-1:2], 2'b00};
        index     = addr[OFF_W +: IDX_W];
        tag       = addr[OFF_W+IDX_W +: TAG_W];
        word      = addr[2 +: WOFF_W];
    end

    assign unused_lsb = ^addr[1:0];
endmodule

// File: rtl/dc_lru.sv
module dc_lru #(
    parameter  int SETS  = 256,
    parameter  int WAYS  = 4,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic             upd_en,
    input  logic [WAY_W-1:0] upd_way,
    output logic [WAY_W-1:0] victim
);
    // Age 0 = most recent, WAYS-1 = least recent.
    logic [WAY_W-1:0] age_q [SETS][WAYS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    age_q[s][w] <= WAY_W'(WAYS - 1 - w);
                end
            end
        end else if (upd_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == upd_way) begin
                    age_q[idx][w] <= '0;
                end else if (age_q[idx][w] < age_q[idx][upd_way]) begin
                    age_q[idx][w] <= age_q[idx][w] + WAY_W'(1);
                end
            end
        end
    end

    always_comb begin
        victim = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (age_q[idx][w] == WAY_W'(WAYS - 1)) begin
                victim = WAY_W'(w);
            end
        end
    end
endmodule

// File: rtl/dc_store.sv
module dc_store #(
    parameter  int SETS   = 256,
    parameter  int WAYS   = 4,
    parameter  int LINE_W = 256,
    parameter  int TAG_W  = 16,
    parameter  int WORD_W = 32,
    localparam int IDX_W  = $clog2(SETS),
    localparam int WAY_W  = $clog2(WAYS),
    localparam int WOFF_W = $clog2(LINE_W / WORD_W)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [IDX_W-1:0]             idx,
    output logic [WAYS-1:0][TAG_W-1:0]   rd_tag,
    output logic [WAYS-1:0]              rd_valid,
    output logic [WAYS-1:0]              rd_dirty,
    output logic [WAYS-1:0][LINE_W-1:0]  rd_line,
    input  logic                         fill_en,
    input  logic [WAY_W-1:0]             fill_way,
    input  logic [TAG_W-1:0]             fill_tag,
    input  logic [LINE_W-1:0]            fill_line,
    input  logic                         word_en,
    input  logic [WAY_W-1:0]             word_way,
    input  logic [WOFF_W-1:0]            word_sel,
    input  logic [WORD_W-1:0]            word_data
);
    logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
    logic [LINE_W-1:0] line_q  [SETS][WAYS];
    logic [WAYS-1:0]   valid_q [SETS];
    logic [WAYS-1:0]   dirty_q [SETS];

    // State bits: reset clears every line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                dirty_q[s] <= '0;
            end
        end else if (fill_en) begin
            valid_q[idx][fill_way] <= 1'b1;
            dirty_q[idx][fill_way] <= 1'b0;
        end else if (word_en) begin
            dirty_q[idx][word_way] <= 1'b1;
        end
    end

    // Payload: no reset needed, guarded by the valid bits.
    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[idx][fill_way]  <= fill_tag;
            line_q[idx][fill_way] <= fill_line;
        end else if (word_en) begin
            line_q[idx][word_way][int'(word_sel)*WORD_W +: WORD_W] <= word_data;
        end
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_rd
        assign rd_tag[w]   = tag_q[idx][w];
        assign rd_line[w]  = line_q[idx][w];
        assign rd_valid[w] = valid_q[idx][w];
        assign rd_dirty[w] = dirty_q[idx][w];
    end
endmodule

// File: rtl/seg_dcache.sv
module seg_dcache
    import dc_pkg::*;
#(
    parameter int SETS       = 256,
    parameter int WAYS       = 4,
    parameter int LINE_WORDS = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cpu_valid,
    output logic        cpu_ready,
    input  logic        cpu_write,
    input  logic [31:0] cpu_addr,
    input  logic [31:0] cpu_wdata,
    output logic        cpu_rvalid,
    output logic [31:0] cpu_rdata,
    output logic        mem_valid,
    input  logic        mem_ready,
    output logic        mem_write,
    output logic        mem_burst,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata
);
    localparam int IDX_W  = $clog2(SETS);
    localparam int WOFF_W = $clog2(LINE_WORDS);
    localparam int OFF_W  = WOFF_W + 2;
    localparam int TAG_W  = PHYS_W - IDX_W - OFF_W;
    localparam int WAY_W  = $clog2(WAYS);
    localparam int LINE_W = LINE_WORDS * XLEN;
    localparam int HI_W   = XLEN - PHYS_W;

    dc_state_e state_q, state_d;

    // Latched request
    logic              req_write_q;
    logic [XLEN-1:0]   req_phys_q;
    logic [XLEN-1:0]   req_wdata_q;
    logic [IDX_W-1:0]  idx_q;
    logic [TAG_W-1:0]  tag_q;
    logic [WOFF_W-1:0] woff_q;

    // Miss handling
    logic [WOFF_W-1:0] beat_q;
    logic [WAY_W-1:0]  way_q;
    logic [LINE_W-1:0] fill_buf_q;

    // Response
    logic              rsp_valid_q;
    logic [XLEN-1:0]   rsp_data_q;

    // Decoder outputs
    logic              dec_unc;
    logic [XLEN-1:0]   dec_phys;
    logic [IDX_W-1:0]  dec_idx;
    logic [TAG_W-1:0]  dec_tag;
    logic [WOFF_W-1:0] dec_woff;

    // Array interface
    logic [WAYS-1:0][TAG_W-1:0]  rd_tag;
    logic [WAYS-1:0]             rd_valid;
    logic [WAYS-1:0]             rd_dirty;
    logic [WAYS-1:0][LINE_W-1:0] rd_line;
    logic                        fill_en;
    logic [LINE_W-1:0]           fill_line_w;
    logic                        word_en;
    logic                        lru_upd;
    logic [WAY_W-1:0]            victim_way;

    logic [WAYS-1:0]   hit_vec;
    logic [WAY_W-1:0]  hit_way;
    logic              hit;
    logic              accept;
    logic              mem_fire;
    logic              beat_last;
    logic [LINE_W-1:0] sel_line;
    logic [XLEN-1:0]   sel_word;

    dc_window_decode #(
        .IDX_W (IDX_W),
        .OFF_W (OFF_W)
    ) u_decode (
        .addr      (cpu_addr),
        .uncached  (dec_unc),
        .phys_word (dec_phys),
        .index     (dec_idx),
        .tag       (dec_tag),
        .word      (dec_woff)
    );

    dc_store #(
        .SETS   (SETS),
        .WAYS   (WAYS),
        .LINE_W (LINE_W),
        .TAG_W  (TAG_W),
        .WORD_W (XLEN)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx       (idx_q),
        .rd_tag    (rd_tag),
        .rd_valid  (rd_valid),
        .rd_dirty  (rd_dirty),
        .rd_line   (rd_line),
        .fill_en   (fill_en),
        .fill_way  (way_q),
        .fill_tag  (tag_q),
        .fill_line (fill_line_w),
        .word_en   (word_en),
        .word_way  (way_q),
        .word_sel  (woff_q),
        .word_data (req_wdata_q)
    );

    dc_lru #(
        .SETS (SETS),
        .WAYS (WAYS)
    ) u_lru (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx     (idx_q),
        .upd_en  (lru_upd),
        .upd_way (way_q),
        .victim  (victim_way)
    );

    // Tag compare
    always_comb begin
        hit_vec = '0;
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (rd_valid[w] && (rd_tag[w] == tag_q)) begin
                hit_vec[w] = 1'b1;
                hit_way    = WAY_W'(w);
            end
        end
        hit = |hit_vec;
    end

    always_comb begin
        accept    = cpu_valid && (state_q == ST_IDLE);
        mem_fire  = mem_valid && mem_ready;
        beat_last = (beat_q == WOFF_W'(LINE_WORDS - 1));
        sel_line  = rd_line[way_q];
        sel_word  = sel_line[int'(woff_q)*XLEN +: XLEN];
        fill_line_w = fill_buf_q;
        fill_line_w[int'(beat_q)*XLEN +: XLEN] = mem_rdata;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = dec_unc ? ST_BYPASS : ST_LOOKUP;
                end
            end
            ST_LOOKUP: begin
                if (hit) begin
                    state_d = ST_COMPLETE;
                end else if (rd_valid[victim_way] && rd_dirty[victim_way]) begin
                    state_d = ST_EVICT;
                end else begin
                    state_d = ST_REFILL;
                end
            end
            ST_EVICT: begin
                if (mem_fire && beat_last) begin
                    state_d = ST_REFILL;
                end
            end
            ST_REFILL: begin
                if (mem_fire && beat_last) begin
                    state_d = ST_COMPLETE;
                end
            end
            ST_COMPLETE: begin
                state_d = ST_IDLE;
            end
            ST_BYPASS: begin
                if (mem_fire) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        cpu_ready = 1'b0;
        mem_valid = 1'b0;
        mem_write = 1'b0;
        mem_burst = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        fill_en   = 1'b0;
        word_en   = 1'b0;
        lru_upd   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cpu_ready = 1'b1;
            end
            ST_LOOKUP: begin
            end
            ST_EVICT: begin
                mem_valid = 1'b1;
                mem_write = 1'b1;
                mem_burst = 1'b1;
                mem_addr  = {{HI_W{1'b0}}, rd_tag[way_q], idx_q, beat_q, 2'b00};
                mem_wdata = sel_line[int'(beat_q)*XLEN +: XLEN];
            end
            ST_REFILL: begin
                mem_valid = 1'b1;
                mem_burst = 1'b1;
                mem_addr  = {{HI_W{1'b0}}, tag_q, idx_q, beat_q, 2'b00};
                fill_en   = mem_fire && beat_last;
            end
            ST_COMPLETE: begin
                word_en = req_write_q;
                lru_upd = 1'b1;
            end
            ST_BYPASS: begin
                mem_valid = 1'b1;
                mem_write = req_write_q;
                mem_addr  = req_phys_q;
                mem_wdata = req_wdata_q;
            end
            default: begin
            end
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_write_q <= 1'b0;
            req_phys_q  <= '0;
            req_wdata_q <= '0;
            idx_q       <= '0;
            tag_q       <= '0;
            woff_q      <= '0;
            beat_q      <= '0;
            way_q       <= '0;
            fill_buf_q  <= '0;
            rsp_valid_q <= 1'b0;
            rsp_data_q  <= '0;
        end else begin
            rsp_valid_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        req_write_q <= cpu_write;
                        req_phys_q  <= dec_phys;
                        req_wdata_q <= cpu_wdata;
                        idx_q       <= dec_idx;
                        tag_q       <= dec_tag;
                        woff_q      <= dec_woff;
                    end
                end
                ST_LOOKUP: begin
                    beat_q <= '0;
                    way_q  <= hit ? hit_way : victim_way;
                end
                ST_EVICT: begin
                    if (mem_fire) begin
                        beat_q <= beat_q + WOFF_W'(1);
                    end
                end
                ST_REFILL: begin
                    if (mem_fire) begin
                        fill_buf_q <= fill_line_w;
                        beat_q     <= beat_q + WOFF_W'(1);
                    end
                end
                ST_COMPLETE: begin
                    rsp_valid_q <= 1'b1;
                    rsp_data_q  <= req_write_q ? req_wdata_q : sel_word;
                end
                ST_BYPASS: begin
                    if (mem_fire) begin
                        rsp_valid_q <= 1'b1;
                        rsp_data_q  <= req_write_q ? req_wdata_q : mem_rdata;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    assign cpu_rvalid = rsp_valid_q;
    assign cpu_rdata  = rsp_data_q;
endmodule

// File: rtl/dc_checker.sv
module dc_checker #(
    parameter int WOFF_W = 3
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cpu_ready,
    input logic        cpu_rvalid,
    input logic        mem_valid,
    input logic        mem_ready,
    input logic        mem_burst,
    input logic [31:0] mem_addr
);
    assert_phys_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (mem_addr[31:29] == 3'b000));

    assert_bypass_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready && !mem_burst) |=> !mem_valid);

    assert_beat_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)));

    assert_burst_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready && mem_burst && (mem_addr[WOFF_W+1:2] != {WOFF_W{1'b1}}))
        |=> (mem_valid && mem_burst && (mem_addr == $past(mem_addr) + 32'd4)));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> !mem_valid);

    assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rvalid |=> !cpu_rvalid);
endmodule

bind seg_dcache dc_checker #(.WOFF_W($clog2(LINE_WORDS))) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_ready  (cpu_ready),
    .cpu_rvalid (cpu_rvalid),
    .mem_valid  (mem_valid),
    .mem_ready  (mem_ready),
    .mem_burst  (mem_burst),
    .mem_addr   (mem_addr)
);

// File: tb/tb_seg_dcache.sv
module tb_seg_dcache;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_valid = 1'b0;
    logic        cpu_ready;
    logic        cpu_write = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_rvalid;
    logic [31:0] cpu_rdata;
    logic        mem_valid;
    logic        mem_ready = 1'b0;
    logic        mem_write;
    logic        mem_burst;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_dcache dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_write(cpu_write),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
        .mem_burst(mem_burst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    typedef struct packed {
        logic        wr;
        logic        burst;
        logic [31:0] addr;
        logic [31:0] data;
    } beat_t;

    int          checks = 0;
    int          failures = 0;
    bit          finished = 0;
    int          beats_seen = 0;
    string       cur_req = "R9";
    beat_t       expq[$];
    string       expreq[$];
    logic [31:0] pmem [int unsigned];
    logic [31:0] mline [int unsigned];
    bit          mdirty [int unsigned];
    int unsigned setq [256][$];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] memrd(input logic [31:0] a);
        if (pmem.exists(a)) return pmem[a];
        return a ^ 32'h5A5A_C3C3;
    endfunction

    function automatic bit is_dirty(input int unsigned line);
        if (mdirty.exists(line)) return mdirty[line];
        return 1'b0;
    endfunction

    // Memory responder and per-cycle comparison of every transfer
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ready = 1'b0;
        end else begin
            if (mem_valid) begin
                beats_seen++;
                if (expq.size() == 0) begin
                    check(1'b0, cur_req, "unexpected memory transfer", mem_addr, 32'h0);
                end else begin
                    beat_t e;
                    string r;
                    e = expq.pop_front();
                    r = expreq.pop_front();
                    check(mem_addr == e.addr, r, "transfer address", mem_addr, e.addr);
                    check({mem_write, mem_burst} == {e.wr, e.burst}, r, "transfer kind",
                          {30'd0, mem_write, mem_burst}, {30'd0, e.wr, e.burst});
                    if (e.wr) check(mem_wdata == e.data, r, "writeback data", mem_wdata, e.data);
                end
                if (mem_write) pmem[mem_addr] = mem_wdata;
                else mem_rdata = memrd(mem_addr);
            end
            mem_ready = mem_valid;
        end
    end

    task automatic push_beat(input bit wr, input bit burst, input logic [31:0] a,
                             input logic [31:0] d, input string r);
        beat_t b;
        b.wr = wr; b.burst = burst; b.addr = a; b.data = d;
        expq.push_back(b);
        expreq.push_back(r);
    endtask

    // Behavioural reference: per-set recency queues, front = most recent
    task automatic model(input bit wr, input logic [31:0] addr, input logic [31:0] wd,
                         output logic [31:0] exp_rd, output int nexp);
        logic [31:0] phys;
        logic [31:0] wa;
        int unsigned line;
        int          s;
        int          found;
        phys = addr & 32'h1FFF_FFFF;
        wa   = phys & 32'hFFFF_FFFC;
        nexp = 0;
        if (addr[31:29] != 3'b100) begin
            push_beat(wr, 1'b0, wa, wd, "R2");
            nexp = 1;
            exp_rd = wr ? wd : memrd(wa);
        end else begin
            line  = phys & 32'hFFFF_FFE0;
            s     = int'((phys >> 5) & 255);
            found = -1;
            for (int i = 0; i < setq[s].size(); i++) if (setq[s][i] == line) found = i;
            if (found >= 0) begin
                setq[s].delete(found);
            end else begin
                if (setq[s].size() == 4) begin
                    int unsigned v;
                    v = setq[s].pop_back();
                    if (is_dirty(v)) begin
                        for (int w = 0; w < 8; w++) push_beat(1'b1, 1'b1, v + 4*w, mline[v + 4*w], "R6");
                        nexp += 8;
                    end
                    mdirty[v] = 1'b0;
                end
                for (int w = 0; w < 8; w++) begin
                    push_beat(1'b0, 1'b1, line + 4*w, 32'h0, "R4");
                    mline[line + 4*w] = memrd(line + 4*w);
                end
                nexp += 8;
                mdirty[line] = 1'b0;
            end
            setq[s].push_front(line);
            if (wr) begin
                mline[wa] = wd;
                mdirty[line] = 1'b1;
                exp_rd = wd;
            end else begin
                exp_rd = mline[wa];
            end
        end
    endtask

    task automatic access(input bit wr, input logic [31:0] addr, input logic [31:0] wd,
                          input string req, output logic [31:0] rd);
        logic [31:0] exp_rd;
        int          nexp;
        int          n;
        @(negedge clk);
        check(cpu_ready == 1'b1, "R9", "ready before request", {31'd0, cpu_ready}, 32'd1);
        cur_req = req;
        beats_seen = 0;
        model(wr, addr, wd, exp_rd, nexp);
        cpu_valid = 1'b1; cpu_write = wr; cpu_addr = addr; cpu_wdata = wd;
        @(negedge clk);
        cpu_valid = 1'b0;
        check(cpu_ready == 1'b0, "R9", "busy after accept", {31'd0, cpu_ready}, 32'd0);
        n = 0;
        while (!cpu_rvalid && n < 1000) begin
            @(negedge clk);
            n++;
        end
        check(cpu_rvalid == 1'b1, "R9", "response pulse", {31'd0, cpu_rvalid}, 32'd1);
        rd = cpu_rdata;
        if (!wr) check(rd == exp_rd, req, "load data", rd, exp_rd);
        check(beats_seen == nexp, req, "transfer count", beats_seen, nexp);
        @(negedge clk);
        check(cpu_rvalid == 1'b0, "R9", "single response pulse", {31'd0, cpu_rvalid}, 32'd0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL R9 watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    localparam logic [31:0] VAL_A = 32'hC15C_0DA7;
    localparam logic [31:0] VAL_B = 32'h0BE1_1A55;
    localparam logic [31:0] VAL_C = 32'h7E57_C0DE;
    localparam logic [31:0] SET2  = 32'h8000_0040;
    localparam logic [31:0] WAYSTRIDE = 32'h0000_2000;

    initial begin
        logic [31:0] rd;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        check(cpu_ready == 1'b1, "R9", "reset ready", {31'd0, cpu_ready}, 32'd1);
        check(mem_valid == 1'b0, "R9", "reset mem idle", {31'd0, mem_valid}, 32'd0);
        check(cpu_rvalid == 1'b0, "R9", "reset no response", {31'd0, cpu_rvalid}, 32'd0);

        // R1/R2: uncached window and addresses outside both windows
        access(1'b0, 32'hA000_1000, 32'h0, "R1", rd);
        access(1'b0, 32'h0000_1004, 32'h0, "R1", rd);
        access(1'b0, 32'hC000_2008, 32'h0, "R1", rd);
        access(1'b1, 32'hE000_300C, 32'h1234_5678, "R1", rd);
        check(memrd(32'h0000_300C) == 32'h1234_5678, "R1", "physical alias of high window",
              memrd(32'h0000_300C), 32'h1234_5678);

        // R4 fill, R3 hit
        access(1'b0, SET2, 32'h0, "R4", rd);
        access(1'b0, SET2 + 32'h1C, 32'h0, "R3", rd);

        // R5 store allocate, then hit store and hit load
        access(1'b1, 32'h8005_FC00, VAL_A, "R5", rd);
        access(1'b1, 32'h8005_FC04, 32'h0000_5EED, "R5", rd);
        access(1'b0, 32'h8005_FC00, 32'h0, "R5", rd);

        // R2: uncached overwrite is hidden by the dirty cached line
        access(1'b1, 32'hA005_FC00, VAL_B, "R2", rd);
        check(memrd(32'h0005_FC00) == VAL_B, "R2", "uncached write reached memory",
              memrd(32'h0005_FC00), VAL_B);
        access(1'b0, 32'h8005_FC00, 32'h0, "R2", rd);
        check(rd == VAL_A, "R2", "cached read still stale", rd, VAL_A);
        access(1'b0, 32'hA005_FC00, 32'h0, "R2", rd);
        check(rd == VAL_B, "R2", "uncached read sees memory", rd, VAL_B);

        // R7/R10: fill set 2, refresh way of SET2, then force evictions
        for (int k = 1; k < 4; k++) access(1'b0, SET2 + k*WAYSTRIDE, 32'h0, "R7", rd);
        access(1'b0, SET2, 32'h0, "R7", rd);                    // hit refreshes it
        access(1'b0, SET2 + 4*WAYSTRIDE, 32'h0, "R10", rd);     // clean victim, no writes
        access(1'b0, SET2, 32'h0, "R7", rd);                    // still resident
        access(1'b0, SET2 + 1*WAYSTRIDE, 32'h0, "R7", rd);      // was evicted, refills
        access(1'b1, SET2 + 3*WAYSTRIDE + 8, 32'hD1D1_0003, "R5", rd);
        for (int k = 5; k < 8; k++) access(1'b0, SET2 + k*WAYSTRIDE, 32'h0, "R7", rd);
        access(1'b0, SET2 + 8*WAYSTRIDE, 32'h0, "R6", rd);      // dirty victim: 8 writes then 8 reads
        check(memrd(32'h0000_6048) == 32'hD1D1_0003, "R6", "dirty word written back",
              memrd(32'h0000_6048), 32'hD1D1_0003);

        // R8: eviction sweep over 128 KB of cached loads
        for (int a = 0; a < 32'h2_0000; a += 32) begin
            access(1'b0, 32'h8000_0000 + a, 32'h0, "R8", rd);
        end
        check(memrd(32'h0005_FC00) == VAL_A, "R8", "stale dirty line written back",
              memrd(32'h0005_FC00), VAL_A);
        check(memrd(32'h0005_FC04) == 32'h0000_5EED, "R8", "second dirty word written back",
              memrd(32'h0005_FC04), 32'h0000_5EED);

        // Overwrite after the sweep, then the cached alias sees it
        access(1'b1, 32'hA005_FC00, VAL_C, "R2", rd);
        access(1'b0, 32'h8005_FC00, 32'h0, "R8", rd);
        check(rd == VAL_C, "R8", "cached read after sweep", rd, VAL_C);
        access(1'b0, 32'hA005_FC00, 32'h0, "R2", rd);
        check(rd == VAL_C, "R2", "uncached read after sweep", rd, VAL_C);

        repeat (4) @(negedge clk);
        check(expq.size() == 0, "R9", "no outstanding transfers", expq.size(), 32'd0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule